// File: doc/BRIEF.md
# Wash-Cycle Sequencer

This block steps a household washing machine through a fixed programme: fill, soak, wash, drain and spin, then a buzzer period, and then it cuts power. A start pulse in the idle state begins the programme. At that moment a one-hot load-size select is captured, and it chooses the duration of every phase. All durations count a slow time-base strobe (`tick`), which comes from outside the block. A single two-digit BCD timer is loaded at each phase entry and counts down to 00. The digits of this timer are presented for display.

While the wash phase runs, two motor lines cycle through a repeating 26-tick pattern that alternates the drum direction. Several conditions latch a power-off that only a synchronous reset clears: an external alarm, lack of water while water should be present, a fill or drain that fails to reach its sensor in time, and a drum strike during spin. While power-off is latched, every actuator output is held inactive.

Top module: `wash_sequencer`

## Requirements
- R1: Phases run strictly in the order fill, soak, wash, drain, spin, buzzer, then power-off. A `start` pulse is acted on only in the idle state and is ignored at all other times. At most one of fill valve, drain valve, motor (either line), spin drive and buzzer is active at a time.
- R2: `loadSel` is captured on the accepted start. The encoding is 3'b100 heavy (fill/drain 12, soak/wash/spin 90), 3'b010 medium (6 and 60), 3'b001 light (6 and 30). Any other code gives 00 for all five phases. The buzzer preset is always 20.
- R3: On entering a phase, the timer loads that phase's preset. The timer decrements in BCD on each `tick`, and the low digit wraps from 0 to 9 with a borrow. The phase output is active while the timer is non-zero. On the clock after the timer reads 00, the next phase is entered. `digitHi`/`digitLo` show the timer.
- R4: A phase with a 00 preset occupies exactly one clock with its output inactive. With all presets 00, the buzzer turns on 5 clocks after the clock that enters fill.
- R5: During active wash, the motor pattern restarts at wash entry and advances one step per tick over 26 steps. Steps 0–9 give motorA=1 and motorB=1. Steps 10–12 give A=0 and B=1. Steps 13–22 give A=1 and B=0. Steps 23–25 give both 0.
- R6: The buzzer sounds for 20 ticks. On the clock after its timer reaches 00, `powerOff` sets.
- R7: `alarmIn` high at any clock edge sets `powerOff` at that edge.
- R8: `waterLow` high while soak or wash is active sets `powerOff`.
- R9: Fill timeout: if `levelOk` has not been high at any clock of the active fill phase up to and including the FILL_LIMIT-th tick (default 8), `powerOff` sets at that tick.
- R10: Drain timeout: the same rule as R9, using `tankEmpty` and DRAIN_LIMIT (default 8).
- R11: `drumStrike` high while spin is active sets `powerOff`. A drum strike in any other phase has no effect.
- R12: `powerOff` stays set until reset. While it is set, all actuator outputs are 0 and the digits read 00. A start is ignored while it is set.
- R13: After reset and while idle, all outputs are 0 and the digits read 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base strobe, one clock wide |
| start | input | 1 | Begin a programme (idle only) |
| loadSel | input | 3 | One-hot load size: [2] heavy, [1] medium, [0] light |
| levelOk | input | 1 | Water level reached sensor |
| tankEmpty | input | 1 | Drum empty sensor |
| waterLow | input | 1 | Lack of water sensor |
| drumStrike | input | 1 | Drum hitting the tub during spin |
| alarmIn | input | 1 | External alarm, forces power-off |
| fillValve | output | 1 | Fill valve drive |
| drainValve | output | 1 | Drain valve drive |
| motorA | output | 1 | Wash motor line A |
| motorB | output | 1 | Wash motor line B |
| spinDrive | output | 1 | Spin drive |
| buzzer | output | 1 | End-of-cycle buzzer |
| powerOff | output | 1 | Latched power cut |
| digitHi | output | 4 | Remaining time, tens digit (BCD) |
| digitLo | output | 4 | Remaining time, units digit (BCD) |

## Verification
Full programmes run with each of the three load sizes at different tick spacings. Each run compares the BCD borrow, the phase boundaries and the motor pattern against a behavioural model on every clock, and the different presets and tick rates separate loading faults from counting faults. An invalid load code exercises the zero-preset skip path and its exact cycle count. Separate runs withhold the level or empty sensor, or assert lack of water, a drum strike or the alarm in chosen phases. These runs confirm that each fault is seen only in its own phase and that power-off is latched.

// File: rtl/wash_seq_pkg.sv
package wash_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_SOAK,
    ST_WASH,
    ST_DRAIN,
    ST_SPIN,
    ST_BUZZ,
    ST_HALT
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   latchSel;
    logic   load;
    phase_e loadPhase;
    logic   run;
    logic   clear;
    logic   drainLimit;
  } ctl_t;

  function automatic logic [7:0] toBcd(input int v);
    logic [3:0] hi;
    logic [3:0] lo;
    hi = 4'(v / 10);
    lo = 4'(v % 10);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/wash_datapath.sv
module wash_datapath
  import wash_seq_pkg::*;
#(
  parameter int HEAVY_SHORT = 12,
  parameter int HEAVY_LONG  = 90,
  parameter int MED_SHORT   = 6,
  parameter int MED_LONG    = 60,
  parameter int LIGHT_SHORT = 6,
  parameter int LIGHT_LONG  = 30,
  parameter int BUZZ_TICKS  = 20,
  parameter int FILL_LIMIT  = 8,
  parameter int DRAIN_LIMIT = 8,
  parameter int BOTH_LEN    = 10,
  parameter int REV1_LEN    = 3,
  parameter int REV2_LEN    = 10,
  parameter int IDLE_LEN    = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  ctl_t       ctl,
  input  logic [2:0] loadSel,
  input  logic       sensorNow,
  output logic [3:0] timerHi,
  output logic [3:0] timerLo,
  output logic       timerBusy,
  output logic       guardHit,
  output logic       seenFlag,
  output logic       patA,
  output logic       patB
);

  localparam logic [7:0] HEAVY_SHORT_B = toBcd(HEAVY_SHORT);
  localparam logic [7:0] HEAVY_LONG_B  = toBcd(HEAVY_LONG);
  localparam logic [7:0] MED_SHORT_B   = toBcd(MED_SHORT);
  localparam logic [7:0] MED_LONG_B    = toBcd(MED_LONG);
  localparam logic [7:0] LIGHT_SHORT_B = toBcd(LIGHT_SHORT);
  localparam logic [7:0] LIGHT_LONG_B  = toBcd(LIGHT_LONG);
  localparam logic [7:0] BUZZ_B        = toBcd(BUZZ_TICKS);

  localparam int GUARD_MAX = (FILL_LIMIT > DRAIN_LIMIT) ? FILL_LIMIT : DRAIN_LIMIT;
  localparam int GUARD_W   = $clog2(GUARD_MAX + 1);
  localparam int PAT_LEN   = BOTH_LEN + REV1_LEN + REV2_LEN + IDLE_LEN;
  localparam int PAT_W     = $clog2(PAT_LEN);
  localparam logic [PAT_W-1:0] PAT_LAST  = PAT_W'(PAT_LEN - 1);
  localparam logic [PAT_W-1:0] EDGE_REV1 = PAT_W'(BOTH_LEN);
  localparam logic [PAT_W-1:0] EDGE_REV2 = PAT_W'(BOTH_LEN + REV1_LEN);
  localparam logic [PAT_W-1:0] EDGE_IDLE = PAT_W'(BOTH_LEN + REV1_LEN + REV2_LEN);

  logic [2:0]         selReg;
  logic [2:0]         selNow;
  logic [7:0]         shortVal;
  logic [7:0]         longVal;
  logic [7:0]         presetVal;
  logic [GUARD_W-1:0] guardCnt;
  logic [GUARD_W-1:0] limitSel;
  logic [PAT_W-1:0]   patIdx;
  logic               stepNow;

  // Load-size capture
  always_ff @(posedge clk) begin
    if (rst)               selReg <= 3'b000;
    else if (ctl.latchSel) selReg <= loadSel;
  end

  assign selNow = ctl.latchSel ? loadSel : selReg;

  // Preset selection
  always_comb begin
    shortVal = 8'h00;
    longVal  = 8'h00;
    case (selNow)
      3'b100: begin shortVal = HEAVY_SHORT_B; longVal = HEAVY_LONG_B; end
      3'b010: begin shortVal = MED_SHORT_B;   longVal = MED_LONG_B;   end
      3'b001: begin shortVal = LIGHT_SHORT_B; longVal = LIGHT_LONG_B; end
      default: ;
    endcase
    case (ctl.loadPhase)
      ST_FILL, ST_DRAIN:         presetVal = shortVal;
      ST_SOAK, ST_WASH, ST_SPIN: presetVal = longVal;
      ST_BUZZ:                   presetVal = BUZZ_B;
      default:                   presetVal = 8'h00;
    endcase
  end

  assign timerBusy = (timerHi != 4'd0) || (timerLo != 4'd0);
  assign stepNow   = ctl.run && timerBusy && tick;

  // Shared two-digit BCD down-counter
  always_ff @(posedge clk) begin
    if (rst || ctl.clear) begin
      timerHi <= 4'd0;
      timerLo <= 4'd0;
    end else if (ctl.load) begin
      timerHi <= presetVal[7:4];
      timerLo <= presetVal[3:0];
    end else if (stepNow) begin
      if (timerLo == 4'd0) begin
        timerLo <= 4'd9;
        timerHi <= timerHi - 4'd1;
      end else begin
        timerLo <= timerLo - 4'd1;
      end
    end
  end

  // Sensor supervision: elapsed ticks and sticky sensor-seen flag
  assign limitSel = ctl.drainLimit ? GUARD_W'(DRAIN_LIMIT) : GUARD_W'(FILL_LIMIT);
  assign guardHit = (guardCnt == (limitSel - GUARD_W'(1)));

  always_ff @(posedge clk) begin
    if (rst || ctl.clear || ctl.load) begin
      guardCnt <= '0;
      seenFlag <= 1'b0;
    end else if (ctl.run && timerBusy) begin
      if (sensorNow) seenFlag <= 1'b1;
      if (tick && (guardCnt != limitSel)) guardCnt <= guardCnt + GUARD_W'(1);
    end
  end

  // Motor reversal pattern step counter
  always_ff @(posedge clk) begin
    if (rst || ctl.clear || ctl.load) patIdx <= '0;
    else if (stepNow)                 patIdx <= (patIdx == PAT_LAST) ? '0 : patIdx + PAT_W'(1);
  end

  assign patA = (patIdx < EDGE_REV1) || ((patIdx >= EDGE_REV2) && (patIdx < EDGE_IDLE));
  assign patB = (patIdx < EDGE_REV2);

endmodule

// File: rtl/wash_control.sv
module wash_control
  import wash_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic start,
  input  logic alarmIn,
  input  logic waterLow,
  input  logic levelOk,
  input  logic tankEmpty,
  input  logic drumStrike,
  input  logic timerBusy,
  input  logic guardHit,
  input  logic seenFlag,
  input  logic patA,
  input  logic patB,
  output ctl_t ctl,
  output logic sensorNow,
  output logic fillValve,
  output logic drainValve,
  output logic motorA,
  output logic motorB,
  output logic spinDrive,
  output logic buzzer,
  output logic powerOff
);

  phase_e state;
  phase_e stateNext;
  logic   powerOffQ;
  logic   finishCycle;
  logic   phaseLive;
  logic   timeoutFault;
  logic   lowWaterFault;
  logic   strikeFault;
  logic   anyFault;

  assign sensorNow = (state == ST_DRAIN) ? tankEmpty : levelOk;

  assign timeoutFault  = ((state == ST_FILL) || (state == ST_DRAIN)) && timerBusy && tick &&
                         guardHit && !seenFlag && !sensorNow;
  assign lowWaterFault = ((state == ST_SOAK) || (state == ST_WASH)) && timerBusy && waterLow;
  assign strikeFault   = (state == ST_SPIN) && timerBusy && drumStrike;
  assign anyFault      = alarmIn || timeoutFault || lowWaterFault || strikeFault;

  always_comb begin
    ctl            = '0;
    ctl.loadPhase  = ST_IDLE;
    ctl.run        = (state != ST_IDLE) && (state != ST_HALT);
    ctl.drainLimit = (state == ST_DRAIN);
    stateNext      = state;
    finishCycle    = 1'b0;
    if (powerOffQ) begin
      stateNext = ST_HALT;
    end else if (anyFault) begin
      stateNext = ST_HALT;
      ctl.clear = 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            ctl.latchSel  = 1'b1;
            ctl.load      = 1'b1;
            ctl.loadPhase = ST_FILL;
            stateNext     = ST_FILL;
          end
        end
        ST_BUZZ: begin
          if (!timerBusy) begin
            stateNext   = ST_HALT;
            ctl.clear   = 1'b1;
            finishCycle = 1'b1;
          end
        end
        ST_HALT: ;
        default: begin
          if (!timerBusy) begin
            stateNext     = phase_e'(state + 3'd1);
            ctl.load      = 1'b1;
            ctl.loadPhase = phase_e'(state + 3'd1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      powerOffQ <= 1'b0;
    end else begin
      state     <= stateNext;
      powerOffQ <= powerOffQ || anyFault || finishCycle;
    end
  end

  assign phaseLive  = timerBusy && !powerOffQ;
  assign fillValve  = (state == ST_FILL)  && phaseLive;
  assign drainValve = (state == ST_DRAIN) && phaseLive;
  assign motorA     = (state == ST_WASH)  && phaseLive && patA;
  assign motorB     = (state == ST_WASH)  && phaseLive && patB;
  assign spinDrive  = (state == ST_SPIN)  && phaseLive;
  assign buzzer     = (state == ST_BUZZ)  && phaseLive;
  assign powerOff   = powerOffQ;

endmodule

// File: rtl/wash_sequencer.sv
module wash_sequencer
  import wash_seq_pkg::*;
#(
  parameter int HEAVY_SHORT = 12,
  parameter int HEAVY_LONG  = 90,
  parameter int MED_SHORT   = 6,
  parameter int MED_LONG    = 60,
  parameter int LIGHT_SHORT = 6,
  parameter int LIGHT_LONG  = 30,
  parameter int BUZZ_TICKS  = 20,
  parameter int FILL_LIMIT  = 8,
  parameter int DRAIN_LIMIT = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       start,
  input  logic [2:0] loadSel,
  input  logic       levelOk,
  input  logic       tankEmpty,
  input  logic       waterLow,
  input  logic       drumStrike,
  input  logic       alarmIn,
  output logic       fillValve,
  output logic       drainValve,
  output logic       motorA,
  output logic       motorB,
  output logic       spinDrive,
  output logic       buzzer,
  output logic       powerOff,
  output logic [3:0] digitHi,
  output logic [3:0] digitLo
);

  ctl_t ctl;
  logic sensorNow;
  logic timerBusy;
  logic guardHit;
  logic seenFlag;
  logic patA;
  logic patB;

  wash_control u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .start      (start),
    .alarmIn    (alarmIn),
    .waterLow   (waterLow),
    .levelOk    (levelOk),
    .tankEmpty  (tankEmpty),
    .drumStrike (drumStrike),
    .timerBusy  (timerBusy),
    .guardHit   (guardHit),
    .seenFlag   (seenFlag),
    .patA       (patA),
    .patB       (patB),
    .ctl        (ctl),
    .sensorNow  (sensorNow),
    .fillValve  (fillValve),
    .drainValve (drainValve),
    .motorA     (motorA),
    .motorB     (motorB),
    .spinDrive  (spinDrive),
    .buzzer     (buzzer),
    .powerOff   (powerOff)
  );

  wash_datapath #(
    .HEAVY_SHORT (HEAVY_SHORT),
    .HEAVY_LONG  (HEAVY_LONG),
    .MED_SHORT   (MED_SHORT),
    .MED_LONG    (MED_LONG),
    .LIGHT_SHORT (LIGHT_SHORT),
    .LIGHT_LONG  (LIGHT_LONG),
    .BUZZ_TICKS  (BUZZ_TICKS),
    .FILL_LIMIT  (FILL_LIMIT),
    .DRAIN_LIMIT (DRAIN_LIMIT)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .ctl       (ctl),
    .loadSel   (loadSel),
    .sensorNow (sensorNow),
    .timerHi   (digitHi),
    .timerLo   (digitLo),
    .timerBusy (timerBusy),
    .guardHit  (guardHit),
    .seenFlag  (seenFlag),
    .patA      (patA),
    .patB      (patB)
  );

endmodule

// File: rtl/wash_sequencer_checker.sv
module wash_sequencer_checker (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       waterLow,
  input logic       drumStrike,
  input logic       alarmIn,
  input logic       fillValve,
  input logic       drainValve,
  input logic       motorA,
  input logic       motorB,
  input logic       spinDrive,
  input logic       buzzer,
  input logic       powerOff,
  input logic [3:0] digitHi,
  input logic [3:0] digitLo
);

  AST_SINGLE_ACTUATOR: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fillValve, drainValve, motorA || motorB, spinDrive, buzzer})); // R1

  AST_DIGITS_BCD: assert property (@(posedge clk) disable iff (rst)
    (digitHi <= 4'd9) && (digitLo <= 4'd9)); // R3

  AST_FILL_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (fillValve && !tick && !alarmIn) |=> ($stable(digitHi) && $stable(digitLo) && fillValve)); // R3

  AST_ALARM_CUT: assert property (@(posedge clk) disable iff (rst)
    alarmIn |=> powerOff); // R7

  AST_LOW_WATER_CUT: assert property (@(posedge clk) disable iff (rst)
    ((motorA || motorB) && waterLow) |=> powerOff); // R8

  AST_STRIKE_CUT: assert property (@(posedge clk) disable iff (rst)
    (spinDrive && drumStrike) |=> powerOff); // R11

  AST_OFF_STICKY: assert property (@(posedge clk) disable iff (rst)
    powerOff |=> powerOff); // R12

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    powerOff |-> !(fillValve || drainValve || motorA || motorB || spinDrive || buzzer)); // R12

endmodule

bind wash_sequencer wash_sequencer_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .waterLow   (waterLow),
  .drumStrike (drumStrike),
  .alarmIn    (alarmIn),
  .fillValve  (fillValve),
  .drainValve (drainValve),
  .motorA     (motorA),
  .motorB     (motorB),
  .spinDrive  (spinDrive),
  .buzzer     (buzzer),
  .powerOff   (powerOff),
  .digitHi    (digitHi),
  .digitLo    (digitLo)
);

// File: tb/wash_sequencer_tb.sv
module wash_sequencer_tb;

  localparam int CLK_PERIOD  = 10;
  localparam int FILL_LIMIT  = 8;
  localparam int DRAIN_LIMIT = 8;
  localparam int WATCHDOG    = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       start = 1'b0;
  logic [2:0] loadSel = 3'b000;
  logic       levelOk = 1'b0;
  logic       tankEmpty = 1'b0;
  logic       waterLow = 1'b0;
  logic       drumStrike = 1'b0;
  logic       alarmIn = 1'b0;
  logic       fillValve, drainValve, motorA, motorB, spinDrive, buzzer, powerOff;
  logic [3:0] digitHi, digitLo;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int tickDiv = 1;
  int tickCnt = 0;
  bit cmpOn = 0;
  bit finished = 0;

  // reference model state (phase codes 0 idle,1 fill,2 soak,3 wash,4 drain,5 spin,6 buzz,7 halt)
  int mSt = 0;
  int mRem = 0;
  int mPat = 0;
  int mGuard = 0;
  bit mSeen = 0;
  bit mOff = 0;
  logic [2:0] mSel = 3'b000;

  wash_sequencer u_dut (
    .clk(clk), .rst(rst), .tick(tick), .start(start), .loadSel(loadSel),
    .levelOk(levelOk), .tankEmpty(tankEmpty), .waterLow(waterLow),
    .drumStrike(drumStrike), .alarmIn(alarmIn),
    .fillValve(fillValve), .drainValve(drainValve), .motorA(motorA), .motorB(motorB),
    .spinDrive(spinDrive), .buzzer(buzzer), .powerOff(powerOff),
    .digitHi(digitHi), .digitLo(digitLo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int mPreset(input int ph, input logic [2:0] sel);
    int s = 0;
    int l = 0;
    if (sel == 3'b100)      begin s = 12; l = 90; end
    else if (sel == 3'b010) begin s = 6;  l = 60; end
    else if (sel == 3'b001) begin s = 6;  l = 30; end
    case (ph)
      1, 4:    return s;
      2, 3, 5: return l;
      6:       return 20;
      default: return 0;
    endcase
  endfunction

  task automatic enterPhase(input int ph);
    mSt = ph;
    mRem = mPreset(ph, mSel);
    mGuard = 0;
    mSeen = 0;
    mPat = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // time base
  always @(negedge clk) begin
    tickCnt++;
    if (tickCnt >= tickDiv) begin tick = 1'b1; tickCnt = 0; end
    else tick = 1'b0;
  end

  // behavioural reference
  always @(posedge clk) begin
    bit sens;
    bit flt;
    int lim;
    if (rst) begin
      mSt = 0; mRem = 0; mPat = 0; mGuard = 0; mSeen = 0; mOff = 0; mSel = 3'b000;
    end else if (!mOff) begin
      sens = (mSt == 4) ? tankEmpty : levelOk;
      lim  = (mSt == 4) ? DRAIN_LIMIT : FILL_LIMIT;
      flt  = alarmIn;
      if ((mSt == 1 || mSt == 4) && mRem > 0 && tick && mGuard == lim - 1 && !mSeen && !sens) flt = 1;
      if ((mSt == 2 || mSt == 3) && mRem > 0 && waterLow) flt = 1;
      if (mSt == 5 && mRem > 0 && drumStrike) flt = 1;
      if (flt) begin
        mOff = 1; mSt = 7; mRem = 0;
      end else if (mSt == 0) begin
        if (start) begin mSel = loadSel; enterPhase(1); end
      end else if (mSt == 7) begin
        mRem = 0;
      end else if (mRem == 0) begin
        if (mSt == 6) begin mSt = 7; mOff = 1; end
        else enterPhase(mSt + 1);
      end else begin
        if (sens) mSeen = 1;
        if (tick) begin
          mRem = mRem - 1;
          if (mGuard < lim) mGuard++;
          mPat = (mPat + 1) % 26;
        end
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    bit busy;
    logic [2:0] eAct;
    logic [1:0] eMot;
    int eDig;
    if (cmpOn && !finished) begin
      busy = (mRem > 0) && !mOff;
      eAct = {mSt == 1 && busy, mSt == 4 && busy, mSt == 5 && busy};
      eMot = 2'b00;
      if (mSt == 3 && busy) begin
        if (mPat < 10)      eMot = 2'b11;
        else if (mPat < 13) eMot = 2'b01;
        else if (mPat < 23) eMot = 2'b10;
      end
      eDig = (mRem / 10) * 16 + (mRem % 10);
      chk({fillValve, drainValve, spinDrive} == eAct, "R3", "fill/drain/spin", {fillValve, drainValve, spinDrive}, eAct);
      chk({motorA, motorB} == eMot, "R5", "motorAB", {motorA, motorB}, eMot);
      chk(buzzer == (mSt == 6 && busy), "R6", "buzzer", buzzer, (mSt == 6 && busy));
      chk(powerOff == mOff, "R12", "powerOff", powerOff, mOff);
      chk({digitHi, digitLo} == eDig[7:0], "R3", "digits", {digitHi, digitLo}, eDig);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      summary();
    end
  end

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; start = 1'b0; alarmIn = 1'b0; waterLow = 1'b0; drumStrike = 1'b0;
    levelOk = 1'b0; tankEmpty = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic pulseStart(input logic [2:0] sel);
    start = 1'b1;
    loadSel = sel;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitOff(output bit prevF, output bit prevD);
    prevF = 0;
    prevD = 0;
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      if (powerOff) break;
      prevF = fillValve;
      prevD = drainValve;
    end
  endtask

  initial begin
    bit pf, pd;
    int n;

    // R13: reset state
    doReset();
    cmpOn = 1;
    @(negedge clk);
    chk(!(fillValve || drainValve || motorA || motorB || spinDrive || buzzer || powerOff), "R13",
        "outputs after reset", {fillValve, drainValve, motorA, motorB, spinDrive, buzzer, powerOff}, 0);
    chk({digitHi, digitLo} == 8'h00, "R13", "idle digits", {digitHi, digitLo}, 0);

    // heavy programme, sensors good
    tickDiv = 3;
    levelOk = 1'b1; tankEmpty = 1'b1;
    pulseStart(3'b100);
    chk({digitHi, digitLo} == 8'h12, "R2", "heavy fill preset", {digitHi, digitLo}, 8'h12);
    chk(fillValve == 1'b1, "R1", "fill first", fillValve, 1);
    repeat (60) @(negedge clk);
    pulseStart(3'b001);  // R1: start ignored mid-programme
    chk(fillValve == 1'b0, "R1", "no restart on start", fillValve, 0);
    waitOff(pf, pd);
    chk(powerOff == 1'b1 && buzzer == 1'b0, "R6", "power off after buzzer", {powerOff, buzzer}, 2'b10);
    chk({digitHi, digitLo} == 8'h00, "R12", "digits when off", {digitHi, digitLo}, 0);
    pulseStart(3'b100);
    chk(fillValve == 1'b0, "R12", "start ignored when off", fillValve, 0);

    // medium programme
    doReset();
    tickDiv = 1;
    levelOk = 1'b1; tankEmpty = 1'b1;
    pulseStart(3'b010);
    chk({digitHi, digitLo} == 8'h06, "R2", "medium fill preset", {digitHi, digitLo}, 8'h06);
    waitOff(pf, pd);
    chk(powerOff == 1'b1, "R1", "medium completes", powerOff, 1);

    // light programme
    doReset();
    tickDiv = 2;
    levelOk = 1'b1; tankEmpty = 1'b1;
    pulseStart(3'b001);
    chk({digitHi, digitLo} == 8'h06, "R2", "light fill preset", {digitHi, digitLo}, 8'h06);
    waitOff(pf, pd);
    chk(powerOff == 1'b1, "R1", "light completes", powerOff, 1);

    // invalid code: all zero presets
    doReset();
    tickDiv = 1;
    pulseStart(3'b011);
    chk({digitHi, digitLo} == 8'h00, "R2", "invalid code preset", {digitHi, digitLo}, 0);
    n = 0;
    while (!buzzer && n < 50) begin @(negedge clk); n++; end
    chk(n == 5, "R4", "clocks to buzzer", n, 5);
    chk({digitHi, digitLo} == 8'h20, "R6", "buzzer preset", {digitHi, digitLo}, 8'h20);
    waitOff(pf, pd);

    // fill timeout
    doReset();
    tickDiv = 2;
    levelOk = 1'b0; tankEmpty = 1'b1;
    pulseStart(3'b100);
    waitOff(pf, pd);
    chk(powerOff && pf && !fillValve, "R9", "fill timeout cut", {powerOff, pf, fillValve}, 3'b110);

    // drain timeout, drum strike outside spin ignored
    doReset();
    tickDiv = 1;
    levelOk = 1'b1; tankEmpty = 1'b0;
    pulseStart(3'b100);
    drumStrike = 1'b1;
    repeat (3) @(negedge clk);
    drumStrike = 1'b0;
    @(negedge clk);
    chk(powerOff == 1'b0, "R11", "strike ignored in fill", powerOff, 0);
    waitOff(pf, pd);
    chk(powerOff && pd, "R10", "drain timeout cut", {powerOff, pd}, 2'b11);

    // lack of water in wash
    doReset();
    tickDiv = 1;
    levelOk = 1'b1; tankEmpty = 1'b1;
    pulseStart(3'b010);
    n = 0;
    while (!(motorA || motorB) && n < 500) begin @(negedge clk); n++; end
    chk(motorA && motorB, "R5", "wash starts both lines", {motorA, motorB}, 2'b11);
    waterLow = 1'b1;
    @(negedge clk);
    waterLow = 1'b0;
    chk(powerOff == 1'b1, "R8", "low water cut", powerOff, 1);
    chk(!(motorA || motorB), "R12", "motor off when cut", {motorA, motorB}, 0);

    // drum strike in spin
    doReset();
    tickDiv = 1;
    levelOk = 1'b1; tankEmpty = 1'b1;
    pulseStart(3'b001);
    n = 0;
    while (!spinDrive && n < 500) begin @(negedge clk); n++; end
    chk(spinDrive == 1'b1, "R1", "spin reached", spinDrive, 1);
    drumStrike = 1'b1;
    @(negedge clk);
    drumStrike = 1'b0;
    chk(powerOff && !spinDrive, "R11", "strike cut", {powerOff, spinDrive}, 2'b10);

    // alarm while idle, then reset clears
    doReset();
    @(negedge clk);
    alarmIn = 1'b1;
    @(negedge clk);
    alarmIn = 1'b0;
    chk(powerOff == 1'b1, "R7", "alarm in idle", powerOff, 1);
    doReset();
    @(negedge clk);
    chk(powerOff == 1'b0, "R12", "reset clears power-off", powerOff, 0);

    // alarm during soak
    levelOk = 1'b1; tankEmpty = 1'b1;
    tickDiv = 1;
    pulseStart(3'b100);
    repeat (20) @(negedge clk);
    alarmIn = 1'b1;
    @(negedge clk);
    alarmIn = 1'b0;
    chk(powerOff == 1'b1, "R7", "alarm in soak", powerOff, 1);
    chk({digitHi, digitLo} == 8'h00, "R12", "digits after alarm", {digitHi, digitLo}, 0);

    repeat (3) @(negedge clk);
    finished = 1;
    summary();
  end

endmodule